// File: doc/BRIEF.md
# Looping Memory Command Generator

This block stands in for one client of a shared memory. Each cycle it may push one command into a downstream command queue. It works through a fixed loop of four phases: a one-cycle setup phase, a burst of writes, a quiet phase, and a burst of reads. The reads revisit the addresses that the writes just covered. The number of accesses per phase, the base address and the 32-bit data word that is replicated across the write payload are all parameters. Two instances with different base addresses therefore exercise disjoint memory regions.

Each command is a single wide word, packed from most to least significant bit as payload data, then address, then a 3-bit operation code. The write strobe marks the cycles that carry a command. Dropping the enable input pauses the loop without losing its place, and raising it again continues from where the loop stopped. A queue-full input stalls the loop in the same way.

Top module: `mem_traffic_gen`

## Requirements
- R1: While reset is asserted (synchronous, active low), and in the first advancing cycle after it, the write strobe is low. The loop always starts in the setup phase.
- R2: The phases run setup (one advancing cycle), write, quiet, read, and then back to setup. One full loop takes 3*N+1 advancing cycles, where N is the accesses-per-phase parameter.
- R3: The write phase issues exactly N commands. Each has operation code 3'b000 in bits [2:0], an address in bits [29:3] equal to base + 8*k for access k = 0..N-1, and a payload in bits [541:30] equal to the 32-bit pattern word replicated 16 times.
- R4: The read phase issues exactly N commands. Each has operation code 3'b001, an all-zero payload, and the same address sequence base + 8*k as the write phase.
- R5: The quiet phase lasts N advancing cycles, and the write strobe stays low throughout.
- R6: While enable is low, the write strobe is low and the phase and access count are held. When enable returns high, the loop resumes with the next access that was due.
- R7: While the queue-full input is high, the write strobe is low and the phase and access count are frozen.
- R8: An advancing cycle is one with enable high and full low. The write strobe is high only in advancing cycles of the write or read phase, so each access is enqueued exactly once per loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | High lets the loop advance; low pauses it |
| fifo_full | input | 1 | Downstream queue full; stalls the loop |
| fifo_wr_en | output | 1 | Command strobe, one cycle per access |
| fifo_din | output | 542 | Command word {data[511:0], addr[26:0], opcode[2:0]} |

## Verification
The embedded assertions check four things on every cycle: the strobe is never raised while paused or while the queue is full, the phase and count hold still in non-advancing cycles, phase changes follow the fixed order, and issued addresses stay inside the window set by the base address. Only the bench's scenarios can show the exact content and order of commands. It predicts the loop position arithmetically across full loops under a pseudo-random mix of enable and full. That covers the address sequence, the payload and code of each phase, the length of the quiet phase, resumption after pauses, and the per-loop count of N writes and N reads.

// File: rtl/tg_pkg.sv
// Package: shared phase type and operation codes for the command generator.
// Assumes: the consumer decodes opcode 3'b000 as write and 3'b001 as read.
package tg_pkg;
    typedef enum logic [1:0] {
        PH_SETUP = 2'd0,
        PH_WRITE = 2'd1,
        PH_QUIET = 2'd2,
        PH_READ  = 2'd3
    } phase_t;

    localparam logic [2:0] OP_WRITE = 3'b000;
    localparam logic [2:0] OP_READ  = 3'b001;

    // Successor of each phase in the fixed loop.
    function automatic phase_t next_phase(input phase_t p);
        case (p)
            PH_SETUP: return PH_WRITE;
            PH_WRITE: return PH_QUIET;
            PH_QUIET: return PH_READ;
            default:  return PH_SETUP;
        endcase
    endfunction
endpackage

// File: rtl/tg_phase_ctrl.sv
// Module: phase sequencer. It holds the current phase and the access count
// within that phase, and moves on only in advancing cycles.
// Assumes: N >= 1; the setup phase lasts one advancing cycle.
module tg_phase_ctrl
    import tg_pkg::*;
#(
    parameter int N     = 25,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output phase_t           phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;

    // Final step of the current phase.
    always_comb last_o = (phase_q == PH_SETUP) || (cnt_q == CNT_LAST);

    // Advance the count, or step to the next phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_SETUP;
            cnt_q   <= '0;
        end else if (go) begin
            if (last_o) begin
                phase_q <= next_phase(phase_q);
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_q;
    assign cnt_o   = cnt_q;

    assert_hold_when_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(phase_q) && $stable(cnt_q)));

    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> (phase_q == next_phase($past(phase_q))));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);
endmodule

// File: rtl/tg_addr_gen.sv
// Module: address offset tracker. It steps by one burst (8 addresses) per
// issued access and clears at every phase end.
// Assumes: an access is never issued on a setup or quiet step.
module tg_addr_gen #(
    parameter int                ADDR_W    = 27,
    parameter int                N         = 25,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              last,
    input  logic              access,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] MAX_OFF = ADDR_W'(8 * (N - 1));

    logic [ADDR_W-1:0] off_q;

    // Offset from the base: cleared at phase end, bumped per access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_q <= '0;
        else if (go && last)
            off_q <= '0;
        else if (access)
            off_q <= off_q + STEP;
    end

    assign addr_o = BASE_ADDR + off_q;

    assert_offset_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= MAX_OFF);
endmodule

// File: rtl/mem_traffic_gen.sv
// Module: looping memory command generator (top). It packs write and read
// commands into {data, address, opcode} and strobes them into a queue.
// Assumes: DATA_W is a multiple of 32; the queue accepts on any strobe
// raised while its full flag is low.
module mem_traffic_gen
    import tg_pkg::*;
#(
    parameter int                ACCESS_CNT = 25,
    parameter int                DATA_W     = 512,
    parameter int                ADDR_W     = 27,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
    parameter logic [31:0]       PAT_WORD   = 32'h5A5A_0F0F,
    localparam int               WORD_W     = DATA_W + ADDR_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fifo_full,
    output logic              fifo_wr_en,
    output logic [WORD_W-1:0] fifo_din
);
    localparam int                REP     = DATA_W / 32;
    localparam int                CNT_W   = $clog2(ACCESS_CNT + 1);
    localparam logic [ADDR_W-1:0] TOP_ADR = BASE_ADDR + ADDR_W'(8 * (ACCESS_CNT - 1));

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic              last;
    logic              go;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [2:0]        opcode;

    // Advancing cycle: running and the queue has room.
    always_comb go = enable && !fifo_full;

    tg_phase_ctrl #(.N(ACCESS_CNT), .CNT_W(CNT_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .phase_o(phase),
        .cnt_o  (cnt),
        .last_o (last)
    );

    tg_addr_gen #(.ADDR_W(ADDR_W), .N(ACCESS_CNT), .BASE_ADDR(BASE_ADDR)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .last  (last),
        .access(fifo_wr_en),
        .addr_o(addr)
    );

    // Strobe only on advancing steps of an access phase.
    always_comb fifo_wr_en = go && ((phase == PH_WRITE) || (phase == PH_READ));

    // Payload and code depend on the phase; reads carry no data.
    always_comb begin
        if (phase == PH_READ) begin
            data   = '0;
            opcode = OP_READ;
        end else begin
            data   = {REP{PAT_WORD}};
            opcode = OP_WRITE;
        end
    end

    assign fifo_din = {data, addr, opcode};

    assert_no_strobe_when_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> (enable && !fifo_full));

    assert_addr_in_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> ((fifo_din[ADDR_W+2:3] >= BASE_ADDR) && (fifo_din[ADDR_W+2:3] <= TOP_ADR)));

    assert_no_strobe_in_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_QUIET) |-> !fifo_wr_en);

    assert_valid_opcode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> (fifo_din[2:1] == 2'b00));
endmodule

// File: tb/mem_traffic_gen_tb.sv
// Bench: predicts the loop position arithmetically and compares every cycle.
module mem_traffic_gen_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          N      = 3;
    localparam int          DATA_W = 512;
    localparam int          ADDR_W = 27;
    localparam int          WORD_W = DATA_W + ADDR_W + 3;
    localparam logic [26:0] BASE   = 27'h0001000;
    localparam logic [31:0] PAT    = 32'hC0DE_1234;
    localparam int          LOOP   = 3 * N + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              fifo_full = 1'b0;
    logic              fifo_wr_en;
    logic [WORD_W-1:0] fifo_din;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  pos      = 0;
    int  wr_seen  = 0;
    int  rd_seen  = 0;
    bit  done     = 1'b0;
    logic [7:0] lfsr = 8'h5D;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_traffic_gen #(
        .ACCESS_CNT(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .BASE_ADDR(BASE), .PAT_WORD(PAT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fifo_full(fifo_full),
        .fifo_wr_en(fifo_wr_en), .fifo_din(fifo_din)
    );

    // Compare one value and record the outcome.
    task automatic check(input string req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive inputs, then at the falling edge compare with the model.
    task automatic step(input logic en, input logic full);
        logic        go_v;
        logic        exp_wr;
        logic [26:0] exp_addr;
        string       tag;
        @(posedge clk);
        #1;
        enable    = en;
        fifo_full = full;
        @(negedge clk);
        go_v   = en && !full;
        exp_wr = go_v && (((pos >= 1) && (pos <= N)) || (pos >= 2 * N + 1));
        if (!en)                              tag = "R6";
        else if (full)                        tag = "R7";
        else if (pos == 0)                    tag = "R2";
        else if (pos <= N)                    tag = "R3";
        else if (pos <= 2 * N)                tag = "R5";
        else                                  tag = "R4";
        check(tag, WORD_W'(fifo_wr_en), WORD_W'(exp_wr));
        if (exp_wr && fifo_wr_en) begin
            if (pos <= N) begin
                exp_addr = BASE + 27'(8 * (pos - 1));
                check("R3", fifo_din, {{16{PAT}}, exp_addr, 3'b000});
                wr_seen++;
            end else begin
                exp_addr = BASE + 27'(8 * (pos - 2 * N - 1));
                check("R4", fifo_din, {512'd0, exp_addr, 3'b001});
                rd_seen++;
            end
        end
        if (go_v) begin
            pos++;
            if (pos == LOOP) begin
                check("R8", WORD_W'(wr_seen), WORD_W'(N));
                check("R8", WORD_W'(rd_seen), WORD_W'(N));
                pos     = 0;
                wr_seen = 0;
                rd_seen = 0;
            end
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: strobe low while reset is held, even with enable high.
        enable = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", WORD_W'(fifo_wr_en), '0);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: first advancing cycle is the setup step.
        check("R1", WORD_W'(fifo_wr_en), '0);
        pos = 1;
        // Two clean loops: R2 R3 R4 R5.
        for (int i = 0; i < 2 * LOOP - 1; i++) step(1'b1, 1'b0);
        // Pause mid write phase (R6), then resume.
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        // Full mid-stream (R7).
        step(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
        for (int i = 0; i < LOOP; i++) step(1'b1, 1'b0);
        // Pseudo-random mix of enable and full across many loops.
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[1:0] != 2'b00, lfsr[4:2] == 3'b000);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule